// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block is the row of boundary-scan cells that sits between a chip's core logic and its I/O pads. Every cell has a shift stage on the serial path and an update latch behind it. There are three kinds of cell. Input cells stand between a pad input and the core. Output cells stand between a core output and a pad. Control cells each set the output enable of one group of output pads. The TAP controller supplies the Capture-DR, Shift-DR and Update-DR strobes, a Test-Logic-Reset level and the decoded current instruction. The block returns the serial TDO bit and drives the core inputs, pad outputs and pad output enables.

In functional operation the cells are transparent: signals pass straight between pins and core. Under the external and internal test instructions, and under the two clamp instructions, the update latches drive both the pins and the core in place of the live signals. This lets a tester drive the board from the pins, or apply a vector to the core one step at a time and capture its response. The clamp instructions reuse whatever the latches already hold and leave the serial path unselected. The floating variant also turns off every output enable.

Top module: `bscan_chain`

## Requirements
- R1: The instruction input decodes as: 1 = sample/preload, 2 = external test, 3 = internal test, 4 = clamp, 5 = clamp-float; 0, 6 and 7 are functional mode. Only codes 1, 2 and 3 select the chain. While it is unselected, TDO is 0, and capture and shift strobes leave the shift stages unchanged.
- R2: With the chain selected and shift asserted, each rising TCK edge moves every shift stage one place toward TDO. TDI enters the highest index (LEN-1), and TDO shows index 0, so a bit applied on TDI appears on TDO after exactly LEN rising edges.
- R3: The chain layout from the TDO end is fixed. Indices 0..N_IN-1 are input cells and capture `pad_in[i]`. Indices N_IN..N_IN+N_OUT-1 are output cells, and output j captures `core_out[j]`. The top N_GRP indices are control cells, and group g captures `core_oe[g]`. Capture takes place on the rising TCK edge while capture is asserted and the chain is selected.
- R4: With the chain selected and update asserted, all update latches copy the shift stages on the falling TCK edge.
- R5: In functional mode (codes 0, 1, 6, 7): `core_in` equals `pad_in`, `pad_out` equals `core_out`, and `pad_oe[j]` equals `core_oe[j / OUT_PER_GRP]`.
- R6: Under external or internal test, `core_in` is driven by the input-cell latches and `pad_out` by the output-cell latches, whatever the live pad and core values are. `pad_oe[j]` is driven by the latch of the control cell for group j / OUT_PER_GRP.
- R7: Under clamp, the pins and the core are driven from the latches as in R6. The latches keep their values even if capture, shift or update strobes arrive.
- R8: Under clamp-float, every `pad_oe` bit is 0, while `core_in` and `pad_out` still come from the latches, and the latches stay unchanged.
- R9: `trst_n` low (asynchronous), or `tlr` high at a TCK edge, clears all shift stages and update latches to 0.
- R10: Under sample/preload, an update loads the latches without disturbing the transparent pins. A later switch to external test drives the preloaded values at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tlr | input | 1 | TAP is in Test-Logic-Reset |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| instr | input | 3 | Decoded current instruction code (see R1) |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| pad_in | input | N_IN | Values arriving from input pads |
| core_in | output | N_IN | Values delivered to core inputs |
| core_out | input | N_OUT | Core output values |
| core_oe | input | N_GRP | Core output enable, one per pad group |
| pad_out | output | N_OUT | Values driven to output pads |
| pad_oe | output | N_OUT | Output pad enables, active high |

## Verification
The assertions assume that the TAP strobes follow the controller's rules. At most one of capture, shift and update is high at a time, and all strobes, the instruction and TDI change only away from TCK edges, so that a falling-edge update sees the values present at the surrounding rising edges. The bench honours this by driving every input one time unit after a rising edge, and by raising only one strobe in any cycle. Random data goes into the pad, core and shift patterns, never into the strobe sequencing, and instruction codes are always drawn from the defined set.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [2:0] {
        OP_FUNC   = 3'd0,
        OP_SAMPLE = 3'd1,
        OP_EXTEST = 3'd2,
        OP_INTEST = 3'd3,
        OP_CLAMP  = 3'd4,
        OP_CLAMPZ = 3'd5
    } bs_op_e;

    typedef struct packed {
        logic chain_sel;   // serial path between TDI and TDO
        logic drive_held;  // latches replace live pin/core values
        logic float_pins;  // all output enables forced off
    } bs_mode_t;

endpackage

// File: rtl/bscan_mode_dec.sv
module bscan_mode_dec
    import bscan_pkg::*;
(
    input  logic [2:0] op,
    output bs_mode_t   mode
);

    always_comb begin
        mode = '0;
        case (op)
            OP_SAMPLE: mode.chain_sel  = 1'b1;
            OP_EXTEST,
            OP_INTEST: begin
                mode.chain_sel  = 1'b1;
                mode.drive_held = 1'b1;
            end
            OP_CLAMP:  mode.drive_held = 1'b1;
            OP_CLAMPZ: begin
                mode.drive_held = 1'b1;
                mode.float_pins = 1'b1;
            end
            default:   mode = '0;
        endcase
    end

endmodule

// File: rtl/bscan_shift.sv
module bscan_shift #(
    parameter int LEN = 12
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           tlr,
    input  logic           sel,
    input  logic           cap_en,
    input  logic           shf_en,
    input  logic           upd_en,
    input  logic           tdi,
    input  logic [LEN-1:0] cap_vec,
    output logic [LEN-1:0] sr_q,
    output logic [LEN-1:0] upd_q,
    output logic           tdo
);

    typedef struct packed {
        logic [LEN-1:0] stage;
    } shreg_t;

    shreg_t         sh_d;
    shreg_t         sh_q;
    logic [LEN-1:0] upd_d;

    // shift stages, rising edge
    always_comb begin
        sh_d = sh_q;
        if (tlr) begin
            sh_d.stage = '0;
        end else if (sel && cap_en) begin
            sh_d.stage = cap_vec;
        end else if (sel && shf_en) begin
            sh_d.stage = {tdi, sh_q.stage[LEN-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    // update latches, falling edge
    always_comb begin
        upd_d = upd_q;
        if (tlr)                 upd_d = '0;
        else if (sel && upd_en)  upd_d = sh_q.stage;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) upd_q <= '0;
        else         upd_q <= upd_d;
    end

    assign sr_q = sh_q.stage;
    assign tdo  = sel & sh_q.stage[0];

endmodule

// File: rtl/bscan_pinmux.sv
module bscan_pinmux
    import bscan_pkg::*;
#(
    parameter int N_IN        = 4,
    parameter int N_GRP       = 2,
    parameter int OUT_PER_GRP = 3,
    localparam int N_OUT      = N_GRP * OUT_PER_GRP
) (
    input  bs_mode_t          mode,
    input  logic [N_IN-1:0]   held_in,
    input  logic [N_OUT-1:0]  held_out,
    input  logic [N_GRP-1:0]  held_oe,
    input  logic [N_IN-1:0]   pad_in,
    input  logic [N_OUT-1:0]  core_out,
    input  logic [N_GRP-1:0]  core_oe,
    output logic [N_IN-1:0]   core_in,
    output logic [N_OUT-1:0]  pad_out,
    output logic [N_OUT-1:0]  pad_oe
);

    assign core_in = mode.drive_held ? held_in : pad_in;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic grp_en;
        assign grp_en = mode.float_pins ? 1'b0
                      : (mode.drive_held ? held_oe[g] : core_oe[g]);
        for (genvar k = 0; k < OUT_PER_GRP; k++) begin : g_pin
            localparam int J = g * OUT_PER_GRP + k;
            assign pad_out[J] = mode.drive_held ? held_out[J] : core_out[J];
            assign pad_oe[J]  = grp_en;
        end
    end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int N_IN        = 4,
    parameter int N_GRP       = 2,
    parameter int OUT_PER_GRP = 3,
    localparam int N_OUT      = N_GRP * OUT_PER_GRP,
    localparam int LEN        = N_IN + N_OUT + N_GRP
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tlr,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic [2:0]       instr,
    input  logic             tdi,
    output logic             tdo,
    input  logic [N_IN-1:0]  pad_in,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_GRP-1:0] core_oe,
    output logic [N_OUT-1:0] pad_out,
    output logic [N_OUT-1:0] pad_oe
);

    localparam int OUT_BASE = N_IN;
    localparam int CTL_BASE = N_IN + N_OUT;

    bs_mode_t       mode;
    logic [LEN-1:0] cap_vec;
    logic [LEN-1:0] sr_q;
    logic [LEN-1:0] upd_q;

    assign cap_vec = {core_oe, core_out, pad_in};

    bscan_mode_dec u_dec (
        .op   (instr),
        .mode (mode)
    );

    bscan_shift #(.LEN(LEN)) u_shift (
        .tck     (tck),
        .trst_n  (trst_n),
        .tlr     (tlr),
        .sel     (mode.chain_sel),
        .cap_en  (capture_dr),
        .shf_en  (shift_dr),
        .upd_en  (update_dr),
        .tdi     (tdi),
        .cap_vec (cap_vec),
        .sr_q    (sr_q),
        .upd_q   (upd_q),
        .tdo     (tdo)
    );

    bscan_pinmux #(
        .N_IN        (N_IN),
        .N_GRP       (N_GRP),
        .OUT_PER_GRP (OUT_PER_GRP)
    ) u_mux (
        .mode     (mode),
        .held_in  (upd_q[N_IN-1:0]),
        .held_out (upd_q[OUT_BASE +: N_OUT]),
        .held_oe  (upd_q[CTL_BASE +: N_GRP]),
        .pad_in   (pad_in),
        .core_out (core_out),
        .core_oe  (core_oe),
        .core_in  (core_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk
    import bscan_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 6,
    parameter int LEN   = 12
) (
    input logic             tck,
    input logic             trst_n,
    input logic             tlr,
    input logic             capture_dr,
    input logic             shift_dr,
    input logic [2:0]       instr,
    input logic             tdo,
    input logic [N_IN-1:0]  pad_in,
    input logic [N_IN-1:0]  core_in,
    input logic [N_OUT-1:0] pad_oe,
    input logic [LEN-1:0]   sr_q,
    input logic [LEN-1:0]   upd_q,
    input bs_mode_t         mode
);

    // R2: one place toward TDO per rising edge while shifting
    assert_shift_step_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (mode.chain_sel && shift_dr && !capture_dr && !tlr)
            |=> (sr_q[0] == $past(sr_q[1])));

    // R1: unselected chain holds its shift stages and keeps TDO low
    assert_unsel_hold_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (!mode.chain_sel && !tlr) |=> $stable(sr_q));

    assert_unsel_tdo_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (instr == OP_CLAMP || instr == OP_CLAMPZ || instr == OP_FUNC) |-> (tdo == 1'b0));

    // R7: clamp instructions never alter the update latches
    assert_clamp_keep_R7: assert property (@(posedge tck) disable iff (!trst_n)
        ((instr == OP_CLAMP || instr == OP_CLAMPZ) && !tlr) |-> $stable(upd_q));

    // R8: floating clamp switches every enable off
    assert_float_oe_R8: assert property (@(posedge tck) disable iff (!trst_n)
        (instr == OP_CLAMPZ) |-> (pad_oe == '0));

    // R5: functional codes keep the core fed from the pads
    assert_func_pass_R5: assert property (@(posedge tck) disable iff (!trst_n)
        (instr == OP_FUNC || instr == OP_SAMPLE || instr == 3'd6 || instr == 3'd7)
            |-> (core_in == pad_in));

    // R9: synchronous test-logic-reset empties the shift stages
    assert_tlr_clear_R9: assert property (@(posedge tck) disable iff (!trst_n)
        tlr |=> (sr_q == '0));

endmodule

bind bscan_chain bscan_chain_chk #(
    .N_IN  (N_IN),
    .N_OUT (N_OUT),
    .LEN   (LEN)
) u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .tlr        (tlr),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .instr      (instr),
    .tdo        (tdo),
    .pad_in     (pad_in),
    .core_in    (core_in),
    .pad_oe     (pad_oe),
    .sr_q       (sr_q),
    .upd_q      (upd_q),
    .mode       (mode)
);

// File: tb/tb_bscan_chain.sv
module tb_bscan_chain;

    localparam int CLK_PERIOD  = 10;
    localparam int N_IN        = 4;
    localparam int N_GRP       = 2;
    localparam int OUT_PER_GRP = 3;
    localparam int N_OUT       = N_GRP * OUT_PER_GRP;
    localparam int LEN         = N_IN + N_OUT + N_GRP;

    logic             tck = 1'b0;
    logic             trst_n, tlr, capture_dr, shift_dr, update_dr, tdi, tdo;
    logic [2:0]       instr;
    logic [N_IN-1:0]  pad_in, core_in;
    logic [N_OUT-1:0] core_out, pad_out, pad_oe;
    logic [N_GRP-1:0] core_oe;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) tck = ~tck;

    bscan_chain #(.N_IN(N_IN), .N_GRP(N_GRP), .OUT_PER_GRP(OUT_PER_GRP)) dut (
        .tck(tck), .trst_n(trst_n), .tlr(tlr), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .instr(instr), .tdi(tdi),
        .tdo(tdo), .pad_in(pad_in), .core_in(core_in), .core_out(core_out),
        .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [N_OUT-1:0] spread(input logic [N_GRP-1:0] g);
        logic [N_OUT-1:0] r;
        for (int j = 0; j < N_OUT; j++) r[j] = g[j / OUT_PER_GRP];
        return r;
    endfunction

    function automatic logic [N_IN-1:0]  f_in (input logic [LEN-1:0] v); return v[N_IN-1:0]; endfunction
    function automatic logic [N_OUT-1:0] f_out(input logic [LEN-1:0] v); return v[N_IN +: N_OUT]; endfunction
    function automatic logic [N_GRP-1:0] f_ctl(input logic [LEN-1:0] v); return v[N_IN+N_OUT +: N_GRP]; endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge tck);
        #1;
    endtask

    task automatic randomize_live();
        pad_in   = N_IN'($urandom);
        core_out = N_OUT'($urandom);
        core_oe  = N_GRP'($urandom);
    endtask

    // optional capture, LEN shifts (tdo collected into got), then update
    task automatic scan(input logic [LEN-1:0] v, input bit do_cap,
                        output logic [LEN-1:0] got);
        if (do_cap) begin
            capture_dr = 1'b1; step(); capture_dr = 1'b0;
        end
        shift_dr = 1'b1;
        for (int k = 0; k < LEN; k++) begin
            tdi = v[k];
            #1 got[k] = tdo;
            step();
        end
        shift_dr  = 1'b0;
        update_dr = 1'b1; step(); update_dr = 1'b0; step();
    endtask

    task automatic chk_held(input string req, input logic [LEN-1:0] v, input bit floating);
        #1;
        chk(req, "core_in",  32'(core_in),  32'(f_in(v)));
        chk(req, "pad_out",  32'(pad_out),  32'(f_out(v)));
        chk(req, "pad_oe",   32'(pad_oe),   floating ? 32'd0 : 32'(spread(f_ctl(v))));
    endtask

    task automatic chk_pass(input string req);
        #1;
        chk(req, "core_in", 32'(core_in), 32'(pad_in));
        chk(req, "pad_out", 32'(pad_out), 32'(core_out));
        chk(req, "pad_oe",  32'(pad_oe),  32'(spread(core_oe)));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [LEN-1:0] v, w, got, cap_exp;
        logic [2*LEN-1:0] pat;
        void'($urandom(32'd20240611));
        trst_n = 1'b0; tlr = 1'b0; capture_dr = 1'b0; shift_dr = 1'b0;
        update_dr = 1'b0; tdi = 1'b0; instr = 3'd0;
        randomize_live();
        step(); step();

        // R9: asynchronous reset leaves all latches at 0
        instr = 3'd2;
        chk_held("R9", '0, 1'b0);
        trst_n = 1'b1;
        step();

        // R5 / R1: functional codes are transparent and TDO is idle
        for (int i = 0; i < 9; i++) begin
            instr = (i % 3 == 0) ? 3'd0 : ((i % 3 == 1) ? 3'd6 : 3'd7);
            randomize_live();
            chk_pass("R5");
            chk("R1", "tdo idle", 32'(tdo), 32'd0);
            step();
        end

        // R3 / R4 / R6: external and internal test with random vectors
        for (int i = 0; i < 8; i++) begin
            instr = (i < 4) ? 3'd2 : 3'd3;
            randomize_live();
            cap_exp = {core_oe, core_out, pad_in};
            v = LEN'($urandom);
            if (i == 0) v = '1;
            if (i == 1) v = '0;
            scan(v, 1'b1, got);
            chk("R3", "captured chain", 32'(got), 32'(cap_exp));
            chk_held("R4", v, 1'b0);
            randomize_live();
            chk_held("R6", v, 1'b0);
        end

        // R2: a TDI bit reaches TDO after exactly LEN rising edges
        instr = 3'd1;
        pat = {($urandom), ($urandom)};
        shift_dr = 1'b1;
        for (int k = 0; k < 2*LEN; k++) begin
            tdi = pat[k];
            #1;
            if (k >= LEN) chk("R2", "tdo delay", 32'(tdo), 32'(pat[k-LEN]));
            step();
        end
        shift_dr = 1'b0;

        // R10: preload under sample keeps pins transparent, then drives under external test
        instr = 3'd1;
        randomize_live();
        cap_exp = {core_oe, core_out, pad_in};
        v = LEN'($urandom);
        scan(v, 1'b1, got);
        chk("R3", "sample capture", 32'(got), 32'(cap_exp));
        randomize_live();
        chk_pass("R10");
        instr = 3'd2;
        chk_held("R10", v, 1'b0);

        // R7: clamp drives held values and ignores all strobes
        instr = 3'd4;
        randomize_live();
        chk_held("R7", v, 1'b0);
        chk("R1", "tdo under clamp", 32'(tdo), 32'd0);
        capture_dr = 1'b1; step(); capture_dr = 1'b0;
        shift_dr = 1'b1;
        for (int k = 0; k < 5; k++) begin tdi = 1'($urandom); step(); end
        shift_dr = 1'b0;
        update_dr = 1'b1; step(); update_dr = 1'b0; step();
        randomize_live();
        chk_held("R7", v, 1'b0);
        instr = 3'd2;
        chk_held("R7", v, 1'b0);

        // R1: shift stages still hold v after the clamp strobes
        instr = 3'd1;
        w = LEN'($urandom);
        scan(w, 1'b0, got);
        chk("R1", "stages untouched", 32'(got), 32'(v));

        // R8: floating clamp
        instr = 3'd5;
        randomize_live();
        chk_held("R8", w, 1'b1);
        update_dr = 1'b1; step(); update_dr = 1'b0;
        capture_dr = 1'b1; step(); capture_dr = 1'b0; step();
        randomize_live();
        chk_held("R8", w, 1'b1);
        instr = 3'd3;
        chk_held("R8", w, 1'b0);

        // R9: test-logic-reset clears latches and stages
        instr = 3'd2;
        tlr = 1'b1; step(); step(); tlr = 1'b0;
        randomize_live();
        chk_held("R9", '0, 1'b0);
        instr = 3'd1;
        scan(LEN'($urandom), 1'b0, got);
        chk("R9", "stages cleared", 32'(got), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule